// File: doc/BRIEF.md
# Power-On and Push-Button Reset Generator

This block drives the active-low reset of a processor from two inputs: a power-good flag supplied by external voltage supervision and a reset push button. While power is not good, or while the button is held, reset stays asserted. Once both inputs have been in their quiet state for a full hold-off interval, reset is released on a clock edge. The default interval is 150 ms, and the block works out the cycle count from the clock frequency.

Any interruption of the quiet state restarts the whole interval. This covers a power dip of one cycle, a single button press and a burst of contact bounce. Because of this, the button needs no separate debouncer: bounce only makes the reset last longer. Assertion of reset does not wait for the clock. Release is always synchronous.

The inputs are sampled through a two-stage synchronizer. The registers start in the reset-asserted state, so the output is low from the moment the block powers up.

Top module: `rstgen_top`

## Requirements
- R1: `rstN` is 0 from time zero and stays 0 until a full hold-off interval has run, even if power is good from the start.
- R2: While `pwrGood` is 0, `rstN` is 0.
- R3: Hold `pwrGood`=1 and `btnPress`=0 at every rising clock edge starting from edge k. Then `rstN` becomes 1 just after edge k+HOLD_CYCLES+2 and not earlier.
- R4: A fall of `pwrGood` drives `rstN` to 0 within the same clock cycle, without waiting for a clock edge.
- R5: While `btnPress` (active high) is 1, `rstN` is 0, and a press drives it low without waiting for a clock edge.
- R6: A button press that lasts at least one clock cycle restarts the full interval. Release follows R3, counted from the first quiet edge after the press.
- R7: A burst of button bounce, meaning several short presses, only delays release. The interval counts from the first quiet edge after the last bounce.
- R8: Once released, `rstN` stays 1 for as long as `pwrGood`=1 and `btnPress`=0.
- R9: A power-good dip that lasts one clock cycle restarts the full interval, exactly as a button press does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that times the hold-off interval |
| pwrGood | input | 1 | 1 when the supply is within range, asynchronous |
| btnPress | input | 1 | 1 while the reset button is pressed, asynchronous |
| rstN | output | 1 | Active-low processor reset |

## Verification
The assertions on the raw pins assume that `pwrGood` and `btnPress` settle between clock edges. Assertions on synchronized state also assume that any input excursion is held across at least one rising edge, so that the synchronizer captures it. The stimulus respects both assumptions. It changes inputs only on the falling clock edge and holds every value for at least one full cycle. Random segments mix long quiet stretches, power dips, presses and bounce bursts within those limits.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  // Commands from control to the hold-off counter
  typedef struct packed {
    logic clear;
    logic advance;
  } timerCmd_t;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } rstState_t;

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] stage1,
  output logic [WIDTH-1:0] stage2
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic firstQ  = INIT[i];
    logic secondQ = INIT[i];
    always_ff @(posedge clk) begin
      firstQ  <= din[i];
      secondQ <= firstQ;
    end
    assign stage1[i] = firstQ;
    assign stage2[i] = secondQ;
  end

endmodule

// File: rtl/rstgen_count.sv
module rstgen_count
  import rstgen_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic      clk,
  input  timerCmd_t cmd,
  output logic      expired
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt = '0;

  always_ff @(posedge clk) begin
    if (cmd.clear)
      cnt <= '0;
    else if (cmd.advance && cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) cnt <= LIMIT);

endmodule

// File: rtl/rstgen_ctrl.sv
module rstgen_ctrl
  import rstgen_pkg::*;
(
  input  logic      clk,
  input  logic      rawOk,
  input  logic      s1Ok,
  input  logic      s2Ok,
  input  logic      expired,
  output timerCmd_t cmd,
  output logic      rstN
);

  rstState_t state = ST_HOLD;
  rstState_t stateNext;
  logic      heldAny;
  logic      pastValid = 1'b0;

  assign heldAny = !s2Ok;

  always_comb begin
    cmd = '0;
    if (heldAny) begin
      cmd.clear = 1'b1;
      stateNext = ST_HOLD;
    end else if (expired) begin
      stateNext = ST_RUN;
    end else begin
      cmd.advance = 1'b1;
      stateNext = ST_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    state     <= stateNext;
    pastValid <= 1'b1;
  end

  // Release only from the registered state; assertion also through every input stage
  assign rstN = (state == ST_RUN) && rawOk && s1Ok && s2Ok;

  // R3
  release_after_expiry_chk: assert property (@(posedge clk) disable iff (!pastValid)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(expired));

  // R6
  held_clears_run_chk: assert property (@(posedge clk) disable iff (!pastValid)
    heldAny |=> state == ST_HOLD);

  // R8
  run_sticky_chk: assert property (@(posedge clk) disable iff (!pastValid)
    (state == ST_RUN && s2Ok) |=> state == ST_RUN);

endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int HOLD_MS     = 150,
  parameter int HOLD_CYCLES = (CLK_HZ / 1000) * HOLD_MS
) (
  input  logic clk,
  input  logic pwrGood,
  input  logic btnPress,
  output logic rstN
);

  logic [1:0] syncIn;
  logic [1:0] stage1;
  logic [1:0] stage2;
  logic       expired;
  timerCmd_t  cmd;

  // bit 1: power good, bit 0: button; power-up values mean "held"
  assign syncIn = {pwrGood, btnPress};

  rstgen_sync #(.WIDTH(2), .INIT(2'b01)) u_sync (
    .clk    (clk),
    .din    (syncIn),
    .stage1 (stage1),
    .stage2 (stage2)
  );

  rstgen_ctrl u_ctrl (
    .clk     (clk),
    .rawOk   (pwrGood && !btnPress),
    .s1Ok    (stage1[1] && !stage1[0]),
    .s2Ok    (stage2[1] && !stage2[0]),
    .expired (expired),
    .cmd     (cmd),
    .rstN    (rstN)
  );

  rstgen_count #(.HOLD_CYCLES(HOLD_CYCLES)) u_count (
    .clk     (clk),
    .cmd     (cmd),
    .expired (expired)
  );

  // R2
  pwr_low_holds_chk: assert property (@(posedge clk) !pwrGood |-> !rstN);

  // R5
  btn_holds_chk: assert property (@(posedge clk) btnPress |-> !rstN);

endmodule

// File: tb/rstgen_top_bench.sv
module rstgen_top_bench;

  localparam int N = 37;
  localparam int LIM = N + 3;

  logic clk = 1'b0;
  logic pwrGood = 1'b0;
  logic btnPress = 1'b0;
  logic rstN;

  int checks = 0;
  int errors = 0;
  int goodRun = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rstgen_top #(.HOLD_CYCLES(N)) u_rstgen_top (
    .clk      (clk),
    .pwrGood  (pwrGood),
    .btnPress (btnPress),
    .rstN     (rstN)
  );

  function automatic logic expectRst(input logic p, input logic b, input int run);
    return p && !b && run >= LIM;
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (rstN !== exp) begin
      errors++;
      $display("FAIL %s: rstN=%b expected %b at %0t", tag, rstN, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, check, pass one rising edge, check again
  task automatic step(input logic p, input logic b, input string tag);
    pwrGood  = p;
    btnPress = b;
    #1 check(tag, expectRst(p, b, goodRun));
    @(posedge clk);
    if (p && !b) begin
      if (goodRun < LIM) goodRun++;
    end else begin
      goodRun = 0;
    end
    #1 check(tag, expectRst(p, b, goodRun));
    @(negedge clk);
  endtask

  task automatic quiet(input int len, input string tag);
    for (int i = 0; i < len; i++) step(1'b1, 1'b0, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    #1 check("R1", 1'b0);
    @(negedge clk);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R2");
    quiet(LIM + 4, "R3");
    quiet(20, "R8");
    step(1'b0, 1'b0, "R4");
    quiet(LIM + 4, "R9");
    step(1'b1, 1'b1, "R5");
    quiet(LIM + 4, "R6");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, "R7");
      step(1'b1, 1'b0, "R7");
    end
    quiet(LIM + 4, "R7");
    for (int seg = 0; seg < 70; seg++) begin
      int kind = $urandom_range(0, 9);
      if (kind <= 5) begin
        quiet($urandom_range(1, N + 20), "R8");
      end else if (kind == 6) begin
        for (int i = 0; i < $urandom_range(1, 5); i++) step(1'b0, 1'($urandom_range(0, 1)), "R9");
      end else if (kind == 7) begin
        for (int i = 0; i < $urandom_range(1, 4); i++) step(1'b1, 1'b1, "R6");
      end else if (kind == 8) begin
        for (int i = 0; i < $urandom_range(2, 8); i++) step(1'b1, 1'(i % 2 == 0), "R7");
      end else begin
        for (int i = 0; i < $urandom_range(1, 10); i++)
          step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2");
      end
    end
    quiet(LIM + 2, "R3");
    finished = 1'b1;
    summary();
  end

endmodule